// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller

This block is the master side of a parallel system bus whose cycles have no fixed length. A local requester hands it one transfer at a time: a cycle kind, an address and, for writes, a data word. The controller presents the address, pulses an address latch strobe, and then asserts the one active-low command line that belongs to the cycle kind. It keeps that line asserted until the addressed slave answers with Ready. Read-type cycles take the data bus word at that moment.

Ready comes from outside the clock domain. It is passed through a two-stage synchroniser before the sequencer uses it. A per-cycle watchdog limit bounds the wait. When the limit runs out, the cycle is closed without a Ready and an error is reported instead of completion. The requester sees a busy level for the whole cycle. It also sees a one-clock completion or error pulse at the end.

Top module: `abus_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it, all five command lines are high, `bus_ale`, `bus_den`, `bus_wdata_oe`, `req_busy`, `cyc_done` and `cyc_err` are low, and `rd_data` is zero.
- R2: A request seen in idle with a legal kind (0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge) raises `req_busy` and gives a one-clock `bus_ale` pulse on the next clock, with every command line still high.
- R3: On the clock after the `bus_ale` pulse, exactly the command line matching the kind goes low and `bus_den` goes high. `bus_addr` equals the request address, and it holds that value from the `bus_ale` clock through the end of the cycle.
- R4: The command line stays low until the synchronised Ready is seen. If Ready rises d clocks after the command line first shows low, the line is low for exactly d+3 sampled clocks.
- R5: For kinds 0, 2 and 4, `rd_data` takes `bus_rdata` at the clock that ends the command phase on Ready. Write cycles and timed-out cycles leave `rd_data` unchanged.
- R6: `bus_wdata_oe` is high only while the command line of kind 1 or 3 is low, and `bus_wdata` then carries the request data.
- R7: If Ready is not seen, the command phase lasts max(`tmo_limit`,1) clocks and then ends with a one-clock `cyc_err` and no `cyc_done`. When Ready arrives on the clock the limit expires, Ready wins.
- R8: After the command phase, the controller spends one clock with all command lines high, `bus_den` and `bus_wdata_oe` low and `req_busy` still high, pulsing `cyc_done` (or `cyc_err`). On the next clock `req_busy` is low.
- R9: Requests are ignored while `req_busy` is high. Kinds 5, 6 and 7 are ignored in idle.
- R10: Ready arriving while no cycle is in progress drives no command line and produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester asks for a cycle |
| req_kind | input | 3 | Cycle kind code (0..4 legal) |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Write data |
| tmo_limit | input | TMO_W | Ready wait limit in clocks |
| req_busy | output | 1 | Cycle in progress |
| cyc_done | output | 1 | One-clock completion pulse |
| cyc_err | output | 1 | One-clock timeout pulse |
| rd_data | output | DATA_W | Last word read |
| bus_addr | output | ADDR_W | Address lines |
| bus_ale | output | 1 | Address latch strobe |
| bus_den | output | 1 | Data transceiver enable |
| bus_wdata | output | DATA_W | Data to the bus |
| bus_wdata_oe | output | 1 | Drive enable for bus_wdata |
| bus_rdata | input | DATA_W | Data from the bus |
| bus_ready | input | 1 | Slave Ready, asynchronous |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |

## Verification
Each of the five cycle kinds is run with different Ready delays. This separates the strobe decoding of each kind and shows which kinds capture data and which drive it. Ready delays are placed just inside, exactly at and just beyond the wait limit, and a zero limit is also used. Together these pin down the synchroniser latency, the watchdog count and the priority between Ready and expiry. Illegal kind codes, a request that arrives mid-cycle, and Ready raised while idle show that stimulus outside a legal cycle changes nothing at the ports.

// File: rtl/abus_pkg.sv
package abus_pkg;

    localparam int KIND_W    = 3;
    localparam int NUM_KINDS = 5;

    localparam logic [KIND_W-1:0] K_MEM_RD  = 3'd0;
    localparam logic [KIND_W-1:0] K_MEM_WR  = 3'd1;
    localparam logic [KIND_W-1:0] K_IO_RD   = 3'd2;
    localparam logic [KIND_W-1:0] K_IO_WR   = 3'd3;
    localparam logic [KIND_W-1:0] K_INT_ACK = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_END  = 2'd3
    } phase_e;

    function automatic logic kind_legal(input logic [KIND_W-1:0] k);
        return k < KIND_W'(NUM_KINDS);
    endfunction

    function automatic logic kind_writes(input logic [KIND_W-1:0] k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic kind_reads(input logic [KIND_W-1:0] k);
        return (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_INT_ACK);
    endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/abus_strobe_dec.sv
module abus_strobe_dec
    import abus_pkg::*;
(
    input  logic              active,
    input  logic [KIND_W-1:0] kind,
    output logic [NUM_KINDS-1:0] strobe_n
);
    generate
        for (genvar i = 0; i < NUM_KINDS; i++) begin : g_line
            localparam logic [KIND_W-1:0] CODE = KIND_W'(i);
            assign strobe_n[i] = !(active && (kind == CODE));
        end
    endgenerate
endmodule

// File: rtl/abus_watchdog.sv
module abus_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] next_ext;

    always_comb begin
        next_ext = {1'b0, cnt_q} + EXT_W'(1);
        cnt_d    = run ? next_ext[CNT_W-1:0] : '0;
        expire   = run && (next_ext >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/abus_cycle_ctrl.sv
module abus_cycle_ctrl
    import abus_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              req_busy,
    output logic              cyc_done,
    output logic              cyc_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_den,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              inta_n
);
    typedef struct packed {
        phase_e             ph;
        logic [KIND_W-1:0]  kind;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic ready_s;
    logic wd_expire;
    logic in_cmd;
    logic [NUM_KINDS-1:0] strobe_n;

    abus_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (ready_s)
    );

    assign in_cmd = (ctl_q.ph == PH_CMD);

    abus_watchdog #(.CNT_W(TMO_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_cmd),
        .limit  (tmo_limit),
        .expire (wd_expire)
    );

    abus_strobe_dec u_dec (
        .active   (in_cmd),
        .kind     (ctl_q.kind),
        .strobe_n (strobe_n)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid && kind_legal(req_kind)) begin
                    ctl_d.ph    = PH_ADDR;
                    ctl_d.kind  = req_kind;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.fail  = 1'b0;
                end
            end
            PH_ADDR: ctl_d.ph = PH_CMD;
            PH_CMD: begin
                if (ready_s) begin
                    ctl_d.ph   = PH_END;
                    ctl_d.fail = 1'b0;
                    if (kind_reads(ctl_q.kind)) ctl_d.rdata = bus_rdata;
                end else if (wd_expire) begin
                    ctl_d.ph   = PH_END;
                    ctl_d.fail = 1'b1;
                end
            end
            PH_END:  ctl_d.ph = PH_IDLE;
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ph    <= PH_IDLE;
            ctl_q.kind  <= '0;
            ctl_q.addr  <= '0;
            ctl_q.wdata <= '0;
            ctl_q.rdata <= '0;
            ctl_q.fail  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_busy     = (ctl_q.ph != PH_IDLE);
    assign cyc_done     = (ctl_q.ph == PH_END) && !ctl_q.fail;
    assign cyc_err      = (ctl_q.ph == PH_END) &&  ctl_q.fail;
    assign rd_data      = ctl_q.rdata;
    assign bus_addr     = ctl_q.addr;
    assign bus_ale      = (ctl_q.ph == PH_ADDR);
    assign bus_den      = in_cmd;
    assign bus_wdata    = ctl_q.wdata;
    assign bus_wdata_oe = in_cmd && kind_writes(ctl_q.kind);

    assign mem_rd_n = strobe_n[K_MEM_RD];
    assign mem_wr_n = strobe_n[K_MEM_WR];
    assign io_rd_n  = strobe_n[K_IO_RD];
    assign io_wr_n  = strobe_n[K_IO_WR];
    assign inta_n   = strobe_n[K_INT_ACK];
endmodule

// File: rtl/abus_cycle_chk.sv
module abus_cycle_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_busy,
    input logic              cyc_done,
    input logic              cyc_err,
    input logic              bus_ale,
    input logic              bus_den,
    input logic              bus_wdata_oe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              io_rd_n,
    input logic              io_wr_n,
    input logic              inta_n
);
    logic [4:0] lines_n;
    assign lines_n = {inta_n, io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~lines_n) <= 1);

    p_den_has_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_den |-> ($countones(~lines_n) == 1));

    p_ale_then_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (!bus_ale && bus_den));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && $past(req_busy)) |-> $stable(bus_addr));

    p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_oe |-> (!mem_wr_n || !io_wr_n));

    p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_done && cyc_err));

    p_end_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done || cyc_err) |=> !req_busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> ((&lines_n) && !bus_den && !bus_ale));
endmodule

bind abus_cycle_ctrl abus_cycle_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_busy     (req_busy),
    .cyc_done     (cyc_done),
    .cyc_err      (cyc_err),
    .bus_ale      (bus_ale),
    .bus_den      (bus_den),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_addr     (bus_addr),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .io_rd_n      (io_rd_n),
    .io_wr_n      (io_wr_n),
    .inta_n       (inta_n)
);

// File: tb/tb_abus_cycle_ctrl.sv
module tb_abus_cycle_ctrl;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_kind;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [TW-1:0] tmo_limit;
    logic          req_busy, cyc_done, cyc_err;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic          bus_ale, bus_den, bus_wdata_oe;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] last_rd = '0;

    abus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
        .req_busy(req_busy), .cyc_done(cyc_done), .cyc_err(cyc_err),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_den(bus_den), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .inta_n(inta_n)
    );

    always #10 clk = ~clk;

    wire [4:0] lines_n = {inta_n, io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [7:0]  delay;
        logic [15:0] limit;
        logic        exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 20'h12345, 16'h0000, 16'hA5A5, 8'd0,  16'd20, 1'b0},
        '{3'd1, 20'hFFFFF, 16'h1234, 16'h0000, 8'd5,  16'd20, 1'b0},
        '{3'd2, 20'h00000, 16'h0000, 16'h5A5A, 8'd2,  16'd20, 1'b0},
        '{3'd3, 20'h003F8, 16'h00FF, 16'h0000, 8'd9,  16'd20, 1'b0},
        '{3'd4, 20'h00000, 16'h0000, 16'h0020, 8'd1,  16'd20, 1'b0},
        '{3'd0, 20'h0A0A0, 16'h0000, 16'hDEAD, 8'd30, 16'd10, 1'b1},
        '{3'd0, 20'h0B0B0, 16'h0000, 16'hBEEF, 8'd7,  16'd10, 1'b0},
        '{3'd3, 20'h0C0C0, 16'h7777, 16'h0000, 8'd8,  16'd10, 1'b1},
        '{3'd2, 20'h0D0D0, 16'h0000, 16'h1111, 8'd5,  16'd0,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cycle(input vec_t v);
        int n;
        int lim;
        int exp_len;
        bit addr_moved;
        bit is_wr;
        bit is_rd;
        logic [4:0] exp_lines;
        lim       = (v.limit == 0) ? 1 : int'(v.limit);
        exp_len   = (int'(v.delay) + 3 < lim) ? int'(v.delay) + 3 : lim;
        is_wr     = (v.kind == 3'd1) || (v.kind == 3'd3);
        is_rd     = !is_wr;
        exp_lines = ~(5'b00001 << v.kind);
        addr_moved = 1'b0;

        tmo_limit = v.limit;
        req_valid = 1'b1;
        req_kind  = v.kind;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_ale == 1'b1, "R2 ale pulse", 32'(bus_ale), 32'd1);
        chk(lines_n == 5'h1f && req_busy, "R2 no strobe yet, busy", 32'({req_busy, lines_n}), 32'h3f);
        chk(bus_addr == v.addr, "R3 address presented", 32'(bus_addr), 32'(v.addr));

        @(negedge clk);
        chk(lines_n == exp_lines, "R3 strobe for kind", 32'(lines_n), 32'(exp_lines));
        chk(bus_den && !bus_ale, "R3 den on, ale off", 32'({bus_den, bus_ale}), 32'h2);
        chk(bus_wdata_oe == is_wr, "R6 write drive enable", 32'(bus_wdata_oe), 32'(is_wr));
        if (is_wr) chk(bus_wdata == v.wdata, "R6 write data", 32'(bus_wdata), 32'(v.wdata));
        n = 1;
        if (v.delay == 0) begin
            bus_ready = 1'b1;
            bus_rdata = v.rdata;
        end
        for (int j = 1; j < 200 && lines_n != 5'h1f; j++) begin
            @(negedge clk);
            if (lines_n != 5'h1f) begin
                n++;
                if (bus_addr != v.addr) addr_moved = 1'b1;
                if (j == int'(v.delay)) begin
                    bus_ready = 1'b1;
                    bus_rdata = v.rdata;
                end
            end
        end
        if (v.exp_err)
            chk(n == exp_len, "R7 timeout length", 32'(n), 32'(exp_len));
        else
            chk(n == exp_len, "R4 strobe held until ready", 32'(n), 32'(exp_len));
        chk(cyc_err == v.exp_err, "R7 error flag", 32'(cyc_err), 32'(v.exp_err));
        chk(cyc_done == !v.exp_err, "R8 done pulse", 32'(cyc_done), 32'(!v.exp_err));
        chk(!bus_den && !bus_wdata_oe && req_busy, "R8 end phase released", 32'({bus_den, bus_wdata_oe, req_busy}), 32'h1);
        chk(!addr_moved && bus_addr == v.addr, "R3 address held", 32'(bus_addr), 32'(v.addr));
        if (is_rd && !v.exp_err) last_rd = v.rdata;
        chk(rd_data == last_rd, "R5 read capture", 32'(rd_data), 32'(last_rd));
        bus_ready = 1'b0;
        @(negedge clk);
        chk(!req_busy && !cyc_done && !cyc_err, "R8 back to idle", 32'({req_busy, cyc_done, cyc_err}), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0;
        req_wdata = '0; tmo_limit = 16'd20; bus_rdata = '0; bus_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(lines_n == 5'h1f, "R1 strobes idle", 32'(lines_n), 32'h1f);
        chk(!bus_ale && !bus_den && !bus_wdata_oe, "R1 bus controls off", 32'({bus_ale, bus_den, bus_wdata_oe}), 32'h0);
        chk(!req_busy && !cyc_done && !cyc_err, "R1 status low", 32'({req_busy, cyc_done, cyc_err}), 32'h0);
        chk(rd_data == '0, "R1 read data zero", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lines_n == 5'h1f && !req_busy, "R1 after release", 32'({req_busy, lines_n}), 32'h1f);

        for (int i = 0; i < NV; i++) run_cycle(VECS[i]);

        // R9 illegal kinds ignored
        for (int k = 5; k < 8; k++) begin
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 20'h55555;
            @(negedge clk);
            req_valid = 1'b0;
            chk(!req_busy && !bus_ale, "R9 illegal kind ignored", 32'({req_busy, bus_ale}), 32'h0);
            @(negedge clk);
            chk(lines_n == 5'h1f && bus_addr != 20'h55555, "R9 no cycle from illegal kind", 32'(lines_n), 32'h1f);
        end

        // R10 ready while idle
        bus_ready = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(lines_n == 5'h1f && !cyc_done && !req_busy, "R10 ready in idle no effect", 32'({cyc_done, req_busy, lines_n}), 32'h1f);
        end
        bus_ready = 1'b0;
        repeat (3) @(negedge clk);

        // R9 request during a cycle ignored
        tmo_limit = 16'd40;
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 20'h00ABC; req_wdata = 16'h4242;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd0; req_addr = 20'h00DEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_addr == 20'h00ABC, "R9 address not replaced", 32'(bus_addr), 32'h00ABC);
        chk(lines_n == 5'h1d, "R9 strobe not replaced", 32'(lines_n), 32'h1d);
        bus_ready = 1'b1;
        for (int j = 0; j < 20 && lines_n != 5'h1f; j++) @(negedge clk);
        bus_ready = 1'b0;
        chk(cyc_done == 1'b1, "R8 done after mid-cycle request", 32'(cyc_done), 32'd1);
        @(negedge clk);
        chk(!req_busy, "R9 no second cycle", 32'(req_busy), 32'h0);
        @(negedge clk);
        chk(!req_busy && !bus_ale, "R9 stays idle", 32'({req_busy, bus_ale}), 32'h0);
        chk(rd_data == last_rd, "R5 write leaves read data", 32'(rd_data), 32'(last_rd));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule